// File: doc/BRIEF.md
# Serial Block-Write Clock-Control Register Slave

This block is a two-wire serial slave that configures a bank of clock-control registers. It watches the serial clock and data lines with a fast system clock, finds START and STOP conditions, and takes only one kind of transaction. That transaction is a block write: an address byte with the write bit, a command byte, a byte count, and then up to the counted number of data bytes. It acknowledges each byte it accepts by pulling the data line low. Data always lands in register 0 first and moves upward one register per byte. There is no index and no read path.

The register bits drive the clock enables and two mode bits directly. A 1 in a field enables the matching output. The master may end a transfer with STOP after any whole byte. The bytes already received stay written, and the registers after them keep their old values.

The control is one finite-state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: receiving the address byte.
- `ST_CMD`: receiving the command byte.
- `ST_COUNT`: receiving the byte count.
- `ST_DATA`: receiving a data byte.
- `ST_ACK`: holding the data line low for the acknowledge clock.
- `ST_SKIP`: ignoring the bus.

The transitions are:
- START, from any state, goes to `ST_ADDR`.
- STOP, from any state, goes to `ST_IDLE`.
- A matching address goes to `ST_ACK` and then `ST_CMD`. A wrong address goes to `ST_SKIP`.
- Any command byte goes to `ST_ACK` and then `ST_COUNT`.
- A count from 1 to 32 goes to `ST_ACK` and then `ST_DATA`. Any other count goes to `ST_SKIP`.
- A data byte inside the count goes to `ST_ACK` and then `ST_DATA`. A data byte past the count goes to `ST_SKIP`.
- `ST_ACK` returns to the saved state on the falling edge of SCL.

Top module: `cfgw_slave`

## Requirements
- R1: After reset, every clock enable reads 1, and both the spread-enable bit and the fast memory mode bit read 0.
- R2: An address byte equal to 0xD2 (slave address 0x69 with the write bit 0) is acknowledged. Any other address byte is not acknowledged. After a wrong address, no later byte is acknowledged and no register changes until the next START.
- R3: The command byte that follows the address is acknowledged whatever its value, and it is not stored in any register.
- R4: A byte count from 1 to 32 is acknowledged. A count of 0, or any count above 32, is not acknowledged, and the transfer then updates no register.
- R5: Serial bits are taken on the rising edge of SCL, most significant bit first. Data byte k of a transfer is written to register k, starting at k = 0.
- R6: A STOP after any whole data byte ends the transfer. The registers already written keep their new values, and all later registers keep their old values.
- R7: A data byte inside the count but at an index of 4 or more is acknowledged and discarded.
- R8: A data byte sent after the counted number of data bytes is not acknowledged, and it changes no register.
- R9: The register fields map to the outputs as follows:
  - Register 0, bit 3: spread enable.
  - Register 0, bits 2..0: `misc_clk_en_o`.
  - Register 1, bits 7..0: `mem_clk_en_o`.
  - Register 2, bits 7..1: `bus_clk_en_o`.
  - Register 3, bit 0: `mem_fast_mode_o`.
  - All other bits are reserved and have no effect.
- R10: For an accepted byte, the acknowledge drive starts after the falling SCL edge that ends the 8th bit and releases after the falling edge that ends the 9th. The drive is never active while the master sends bits, and it never changes while SCL is high.
- R11: A repeated START in the middle of a transfer restarts address reception. The bytes that follow are treated as a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_drive_o | output | 1 | 1 pulls the data line low (acknowledge) |
| spread_en_o | output | 1 | Spread-spectrum enable (register 0 bit 3) |
| misc_clk_en_o | output | 3 | Miscellaneous clock enables (register 0 bits 2..0) |
| mem_clk_en_o | output | 8 | Memory clock enables (register 1) |
| bus_clk_en_o | output | 7 | Bus and fixed-rate clock enables (register 2 bits 7..1) |
| mem_fast_mode_o | output | 1 | Fast memory clock mode (register 3 bit 0) |

## Verification
Some rules are checked by the assertions on every cycle:
- The acknowledge drive starts only right after a detected falling SCL edge, and it stays steady while SCL is high.
- The remaining-byte counter never exceeds the maximum count.
- A register write comes only from the data phase and only to an implemented index.
- The register bank holds its value whenever no write is strobed.

Other behaviour can only be shown by the bench scenarios, because it depends on whole byte sequences: which bytes get an acknowledge, what happens after a wrong address or a bad count, STOP part way through a transfer, discarded bytes past the register range, repeated START, and the mapping of each field to its output.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_ACK,
        ST_SKIP
    } cfgw_state_t;

    // Value loaded into register idx at reset: enables on, modes off.
    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

    // Implemented bits of register idx; reserved bits are stored as 0.
    function automatic logic [7:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'h0F;
            1:       return 8'hFF;
            2:       return 8'hFE;
            3:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgw_line_sampler.sv
module cfgw_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_det,
    output logic stop_det
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sync;
    logic [TOP:0] sda_sync;
    logic         scl_prev;
    logic         sda_prev;

    // Synchronizer chains and one cycle of history; the idle bus is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[TOP-1:0], scl_i};
            sda_sync <= {sda_sync[TOP-1:0], sda_i};
            scl_prev <= scl_sync[TOP];
            sda_prev <= sda_sync[TOP];
        end
    end

    assign scl_hi    = scl_sync[TOP];
    assign sda_bit   = sda_sync[TOP];
    assign scl_rise  = scl_sync[TOP] && !scl_prev;
    assign scl_fall  = !scl_sync[TOP] && scl_prev;
    assign start_det = scl_sync[TOP] && scl_prev && sda_prev && !sda_sync[TOP];
    assign stop_det  = scl_sync[TOP] && scl_prev && !sda_prev && sda_sync[TOP];

endmodule

// File: rtl/cfgw_reg_bank.sv
module cfgw_reg_bank
    import cfgw_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic [7:0] bank_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[i] <= reg_reset(i);
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                bank_q[i] <= wr_data & reg_mask(i);
            end
        end
        assign regs_flat[i*8 +: 8] = bank_q[i];
    end

    // The sequencer only strobes indices that exist here.
    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    // Without a write strobe the contents cannot move.
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

endmodule

// File: rtl/cfgw_slave.sv
module cfgw_slave
    import cfgw_pkg::*;
#(
    parameter logic [7:0] ADDR_BYTE   = 8'hD2,
    parameter int         MAX_COUNT   = 32,
    parameter int         NUM_REGS    = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_o,
    output logic       spread_en_o,
    output logic [2:0] misc_clk_en_o,
    output logic [7:0] mem_clk_en_o,
    output logic [6:0] bus_clk_en_o,
    output logic       mem_fast_mode_o
);

    localparam int CNT_W = $clog2(MAX_COUNT + 1);
    localparam int REG_W = NUM_REGS * 8;

    logic scl_hi, scl_rise, scl_fall, sda_bit, start_det, stop_det;

    cfgw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_hi    (scl_hi),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgw_state_t      state, state_n, ret_q, ret_n;
    logic [7:0]       shreg;
    logic [3:0]       bit_cnt;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] data_idx;
    logic             wr_en;
    logic [CNT_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic             sda_drive_q;
    logic [REG_W-1:0] regs_flat;

    logic rx_state, byte_done, count_ok;

    assign rx_state  = (state == ST_ADDR) || (state == ST_CMD) ||
                       (state == ST_COUNT) || (state == ST_DATA);
    assign byte_done = rx_state && (bit_cnt == 4'd8) && scl_fall;
    assign count_ok  = (shreg != 8'd0) && (int'(shreg) <= MAX_COUNT);

    // Next-state logic.
    always_comb begin
        state_n = state;
        ret_n   = ret_q;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: state_n = state;
                ST_ADDR: if (byte_done) begin
                    if (shreg == ADDR_BYTE) begin
                        state_n = ST_ACK;
                        ret_n   = ST_CMD;
                    end else begin
                        state_n = ST_SKIP;
                    end
                end
                ST_CMD: if (byte_done) begin
                    state_n = ST_ACK;
                    ret_n   = ST_COUNT;
                end
                ST_COUNT: if (byte_done) begin
                    if (count_ok) begin
                        state_n = ST_ACK;
                        ret_n   = ST_DATA;
                    end else begin
                        state_n = ST_SKIP;
                    end
                end
                ST_DATA: if (byte_done) begin
                    if (remain != '0) begin
                        state_n = ST_ACK;
                        ret_n   = ST_DATA;
                    end else begin
                        state_n = ST_SKIP;
                    end
                end
                ST_ACK: if (scl_fall) state_n = ret_q;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ret_q <= ST_IDLE;
        end else begin
            state <= state_n;
            ret_q <= ret_n;
        end
    end

    // Outputs and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            bit_cnt     <= '0;
            remain      <= '0;
            data_idx    <= '0;
            wr_en       <= 1'b0;
            wr_idx      <= '0;
            wr_data     <= '0;
            sda_drive_q <= 1'b0;
        end else begin
            wr_en       <= 1'b0;
            sda_drive_q <= (state_n == ST_ACK);
            if (start_det || (state == ST_ACK && scl_fall)) begin
                bit_cnt <= '0;
            end else if (rx_state && scl_rise && bit_cnt < 4'd8) begin
                shreg   <= {shreg[6:0], sda_bit};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (!start_det && !stop_det && byte_done) begin
                if (state == ST_COUNT && count_ok) begin
                    remain   <= shreg[CNT_W-1:0];
                    data_idx <= '0;
                end
                if (state == ST_DATA && remain != '0) begin
                    remain   <= remain - 1'b1;
                    data_idx <= data_idx + 1'b1;
                    wr_en    <= (int'(data_idx) < NUM_REGS);
                    wr_idx   <= data_idx;
                    wr_data  <= shreg;
                end
            end
        end
    end

    cfgw_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    assign sda_drive_o     = sda_drive_q;
    assign misc_clk_en_o   = regs_flat[2:0];
    assign spread_en_o     = regs_flat[3];
    assign mem_clk_en_o    = regs_flat[15:8];
    assign bus_clk_en_o    = regs_flat[23:17];
    assign mem_fast_mode_o = regs_flat[24];

    logic unused_bits;
    assign unused_bits = ^{regs_flat[7:4], regs_flat[16], regs_flat[REG_W-1:25]};

    assert_ack_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_o) |-> $past(scl_fall));

    assert_ack_steady_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && $past(scl_hi)) |-> $stable(sda_drive_o));

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(remain) <= MAX_COUNT);

    assert_write_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(state) == ST_DATA));

    assert_silent_in_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && $past(state) == ST_SKIP) |-> !sda_drive_o);

endmodule

// File: tb/sim_cfgw_slave.sv
module sim_cfgw_slave;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive;
    logic spread_en, fast_mode;
    logic [2:0] misc_en;
    logic [7:0] mem_en;
    logic [6:0] bus_en;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int stray = 0;
    logic [7:0] dbuf [0:7];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_drive;

    cfgw_slave u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .sda_drive_o     (sda_drive),
        .spread_en_o     (spread_en),
        .misc_clk_en_o   (misc_en),
        .mem_clk_en_o    (mem_en),
        .bus_clk_en_o    (bus_en),
        .mem_fast_mode_o (fast_mode)
    );

    // Observation packing: {fast, bus[6:0], mem[7:0], spread, misc[2:0]}.
    // Vector entry: {count, d0, d1, d2, d3, expected observation}.
    localparam logic [59:0] VEC [0:4] = '{
        {8'd4, 8'h08, 8'h00, 8'h00, 8'h01, 1'b1, 7'h00, 8'h00, 1'b1, 3'b000},
        {8'd4, 8'hF5, 8'hA5, 8'h3C, 8'hFE, 1'b0, 7'h1E, 8'hA5, 1'b0, 3'b101},
        {8'd2, 8'h0E, 8'h5A, 8'h00, 8'h00, 1'b0, 7'h1E, 8'h5A, 1'b1, 3'b110},
        {8'd3, 8'h03, 8'h81, 8'hC3, 8'h00, 1'b0, 7'h61, 8'h81, 1'b0, 3'b011},
        {8'd1, 8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 7'h61, 8'h81, 1'b1, 3'b111}
    };

    function automatic logic [19:0] observe();
        return {fast_mode, bus_en, mem_en, spread_en, misc_en};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq();
            @(negedge clk);
            if (sda_drive) stray++;
            wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        @(negedge clk);
        ack = sda_drive;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] c, input logic [7:0] cnt,
                        input int n, input bit do_stop, output logic [11:0] acks);
        logic k;
        acks = '0;
        bus_start();
        send_byte(a, k);   acks[0] = k;
        send_byte(c, k);   acks[1] = k;
        send_byte(cnt, k); acks[2] = k;
        for (int i = 0; i < n; i++) begin
            send_byte(dbuf[i], k);
            acks[3+i] = k;
        end
        if (do_stop) bus_stop();
        repeat (4) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [11:0] acks;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset outputs", 32'(observe()), 32'({1'b0, 7'h7F, 8'hFF, 1'b0, 3'b111}));
        check("R10 idle drive", 32'(sda_drive), 32'd0);

        // R5 R9: table of block writes
        for (int v = 0; v < 5; v++) begin
            int n;
            n = int'(VEC[v][59:52]);
            dbuf[0] = VEC[v][51:44];
            dbuf[1] = VEC[v][43:36];
            dbuf[2] = VEC[v][35:28];
            dbuf[3] = VEC[v][27:20];
            xfer(8'hD2, 8'h00, VEC[v][59:52], n, 1'b1, acks);
            check("R5 R2 acks of vector", 32'(acks), 32'((12'd1 << (3 + n)) - 12'd1));
            @(negedge clk);
            check("R9 R5 R6 fields of vector", 32'(observe()), 32'(VEC[v][19:0]));
        end

        // R2: wrong address, bus ignored
        for (int i = 0; i < 4; i++) dbuf[i] = 8'h00;
        xfer(8'hD4, 8'h00, 8'd4, 4, 1'b1, acks);
        check("R2 wrong address no acks", 32'(acks), 32'd0);
        check("R2 wrong address regs kept", 32'(observe()), 32'({1'b0, 7'h61, 8'h81, 1'b1, 3'b111}));

        // R4: count of 0 and of 33
        xfer(8'hD2, 8'h00, 8'd0, 1, 1'b1, acks);
        check("R4 count zero nacked", 32'(acks), 32'h003);
        xfer(8'hD2, 8'h00, 8'd33, 1, 1'b1, acks);
        check("R4 count 33 nacked", 32'(acks), 32'h003);
        check("R4 regs kept", 32'(observe()), 32'({1'b0, 7'h61, 8'h81, 1'b1, 3'b111}));

        // R7 R6: max count, bytes past range acked, early stop
        dbuf[0] = 8'h00; dbuf[1] = 8'hFF; dbuf[2] = 8'hFF; dbuf[3] = 8'h00;
        for (int i = 4; i < 8; i++) dbuf[i] = 8'h55;
        xfer(8'hD2, 8'h00, 8'd32, 8, 1'b1, acks);
        check("R7 bytes past range acked", 32'(acks), 32'h7FF);
        check("R7 R6 regs after early stop", 32'(observe()), 32'({1'b0, 7'h7F, 8'hFF, 1'b0, 3'b000}));

        // R8: byte beyond count
        dbuf[0] = 8'h0B; dbuf[1] = 8'h12; dbuf[2] = 8'hAA;
        xfer(8'hD2, 8'h00, 8'd2, 3, 1'b1, acks);
        check("R8 extra byte nacked", 32'(acks), 32'h01F);
        check("R8 extra byte not stored", 32'(observe()), 32'({1'b0, 7'h7F, 8'h12, 1'b1, 3'b011}));

        // R3: nonzero command byte
        dbuf[0] = 8'h04;
        xfer(8'hD2, 8'h5A, 8'd1, 1, 1'b1, acks);
        check("R3 command acked", 32'(acks), 32'h00F);
        check("R3 command not stored", 32'(observe()), 32'({1'b0, 7'h7F, 8'h12, 1'b0, 3'b100}));

        // R11: repeated START mid transfer
        dbuf[0] = 8'h01;
        xfer(8'hD2, 8'h00, 8'd4, 1, 1'b0, acks);
        check("R11 first part acks", 32'(acks), 32'h00F);
        dbuf[0] = 8'h06;
        xfer(8'hD2, 8'h00, 8'd1, 1, 1'b1, acks);
        check("R11 restart acks", 32'(acks), 32'h00F);
        check("R11 restart regs", 32'(observe()), 32'({1'b0, 7'h7F, 8'h12, 1'b0, 3'b110}));

        check("R10 no drive during master bits", 32'(stray), 32'd0);
        finish_run();
    end

endmodule